// File: doc/BRIEF.md
# Indexed Addressing Cycle Sequencer

This block is the per-cycle control sequencer for the indexed addressing forms of an 8-bit processor core with a 13-bit address bus. It fetches an opcode from the data bus, recognises zero-page indexed and absolute indexed instructions, and then walks through their bus cycles. In each cycle it drives the address, a read/write strobe (1 = write), an ALU enable and the ALU opcode. It fetches the operand bytes, adds the selected index register and forms the effective address. For absolute forms it inserts an extra correction cycle when the low-byte addition carries into the next page. For zero-page forms the sum wraps inside page zero.

Three instruction classes are sequenced. Reads (loads, logic, add, subtract, compare) hand their ALU work to the following opcode fetch cycle. Stores write once at the indexed zero-page address. Read-modify-write operations read, then write twice, with the ALU active only on the first write. The core places the index values on `idx_x`/`idx_y`. Memory returns data on `data_in` in the same cycle as the address.

The opcode byte uses a fixed layout. Bits [7:6] give the mode: 01 is zero-page indexed, 10 is absolute indexed, and 00 or 11 is a plain opcode that this block finishes in the fetch cycle. Bits [5:4] give the class: 00 or 11 is read, 01 is store and 10 is read-modify-write. Bit 3 selects the index: 1 is Y and 0 is X. Bits [2:0] take no part in sequencing. They reach the ALU as part of the opcode.

Top module: `idx_seq`

## Requirements
- R1: While `rst_n` is low, `addr` equals `rst_pc` and `wr`, `alu_en` and `alu_op` are all 0.
- R2: An opcode fetch reads at PC, and PC then advances by one modulo 2^13. An opcode with mode bits [7:6] = 00 or 11 is complete after its fetch cycle, so the next cycle is again a fetch.
- R3: In absolute indexed mode (bits [7:6] = 10), cycles 2 and 3 read the low and high address bytes at the two successive PC values.
- R4: Cycle 4 of an absolute indexed instruction reads at {high byte bits [4:0], (low byte + index) mod 256}.
- R5: When low byte + index exceeds 255, cycle 5 reads at {(high bits [4:0] + 1) mod 32, wrapped low byte}. Otherwise the cycle after cycle 4 is an opcode fetch.
- R6: In zero-page indexed mode (bits [7:6] = 01), cycle 2 reads the base byte at PC. Cycle 3 is a dummy read at the base address in page zero. Cycle 4 accesses (base + index) mod 256 in page zero.
- R7: Opcode bit 3 selects the index in both indexed modes: 1 uses `idx_y` and 0 uses `idx_x`.
- R8: A zero-page store (class bits [5:4] = 01) drives `wr` = 1 in its fourth cycle at the indexed address, and the next cycle is a fetch.
- R9: A zero-page read-modify-write (class 10) reads in cycle 4. Cycle 5 writes with `alu_en` = 1 and `alu_op` equal to the opcode. Cycle 6 writes with the ALU idle. All three cycles use the same address.
- R10: For a read-class indexed instruction (class 00 or 11), `alu_en` = 1 and `alu_op` equals its opcode during the next opcode fetch, and during that cycle only.
- R11: In every other cycle `alu_en` and `alu_op` are 0. `wr` is 0 outside the write cycles named in R8 and R9.
- R12: In absolute indexed mode the class bits are ignored, and store or read-modify-write encodings follow the read sequence.
- R13: After `rst_n` rises, the first opcode fetch is the one in progress after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_pc | input | 13 | Program counter value loaded during reset |
| data_in | input | 8 | Data bus read value |
| idx_x | input | 8 | Current X index value |
| idx_y | input | 8 | Current Y index value |
| addr | output | 13 | Address bus |
| wr | output | 1 | Read/write strobe, 1 = write |
| alu_en | output | 1 | ALU enable |
| alu_op | output | 8 | ALU opcode, 0 when idle |

## Verification
Every internal register of this block shows up on the address bus within a few cycles. A wrong PC or a misaligned state shows in the next fetch or operand cycle. A lost carry or a wrong high byte moves the cycle-4 or cycle-5 address, or removes the fifth cycle, and this shifts every later cycle of the trace. A lost or stale pending ALU request shows in the very next fetch as a wrong `alu_en`/`alu_op` pair. So the trace is compared against the model on every clock, which places each fault within the instruction that caused it.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  // Header: the opcode bits that steer sequencing, taken as one slice
  localparam int HDR_LSB = 3;
  localparam int HDR_W   = 5;

  // Field positions inside the header slice
  localparam int H_MODE_HI = 4;
  localparam int H_MODE_LO = 3;
  localparam int H_CLS_HI  = 2;
  localparam int H_CLS_LO  = 1;
  localparam int H_SEL     = 0;

  localparam logic [1:0] MODE_ZPG = 2'b01;
  localparam logic [1:0] MODE_ABS = 2'b10;
  localparam logic [1:0] CLS_STO  = 2'b01;
  localparam logic [1:0] CLS_RMW  = 2'b10;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPA,
    ST_OPB,
    ST_EA,
    ST_FIX,
    ST_MOD,
    ST_WB
  } seq_state_t;

  typedef struct packed {
    logic is_zp;
    logic is_abs;
    logic is_store;
    logic is_rmw;
    logic use_y;
  } op_class_t;

endpackage

// File: rtl/idx_seq_decode.sv
module idx_seq_decode
  import idx_seq_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output op_class_t        cls
);

  logic [1:0] mode;
  logic [1:0] kind;

  assign mode = hdr[H_MODE_HI:H_MODE_LO];
  assign kind = hdr[H_CLS_HI:H_CLS_LO];

  always_comb begin
    cls.is_zp    = (mode == MODE_ZPG);
    cls.is_abs   = (mode == MODE_ABS);
    // class bits only matter in zero-page mode
    cls.is_store = (mode == MODE_ZPG) && (kind == CLS_STO);
    cls.is_rmw   = (mode == MODE_ZPG) && (kind == CLS_RMW);
    cls.use_y    = hdr[H_SEL];
  end

endmodule

// File: rtl/idx_seq_agen.sv
module idx_seq_agen #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]        base,
  input  logic [DATA_W-1:0]        index,
  input  logic [ADDR_W-DATA_W-1:0] hi_part,
  input  logic [DATA_W-1:0]        eff_lo,
  output logic [DATA_W-1:0]        sum_lo,
  output logic                     carry,
  output logic [ADDR_W-1:0]        ea_zp_base,
  output logic [ADDR_W-1:0]        ea_zp,
  output logic [ADDR_W-1:0]        ea_abs,
  output logic [ADDR_W-1:0]        ea_fix
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W:0] sum;
  logic [HI_W-1:0] hi_inc;

  assign sum    = {1'b0, base} + {1'b0, index};
  assign sum_lo = sum[DATA_W-1:0];
  assign carry  = sum[DATA_W];
  assign hi_inc = hi_part + {{(HI_W-1){1'b0}}, 1'b1};

  assign ea_zp_base = {{HI_W{1'b0}}, base};
  assign ea_zp      = {{HI_W{1'b0}}, eff_lo};
  assign ea_abs     = {hi_part, eff_lo};
  assign ea_fix     = {hi_inc, eff_lo};

endmodule

// File: rtl/idx_seq_ctrl.sv
module idx_seq_ctrl
  import idx_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rst_pc,
  input  logic [DATA_W-1:0]        data_in,
  input  logic                     is_zp,
  input  logic                     is_abs,
  input  logic                     is_store,
  input  logic                     is_rmw,
  input  logic [DATA_W-1:0]        sum_lo,
  input  logic                     carry,
  input  logic [ADDR_W-1:0]        ea_zp_base,
  input  logic [ADDR_W-1:0]        ea_zp,
  input  logic [ADDR_W-1:0]        ea_abs,
  input  logic [ADDR_W-1:0]        ea_fix,
  output logic [HDR_W-1:0]         op_hdr,
  output logic [DATA_W-1:0]        base_q,
  output logic [ADDR_W-DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0]        eff_lo_q,
  output logic [ADDR_W-1:0]        addr,
  output logic                     wr,
  output logic                     alu_en,
  output logic [DATA_W-1:0]        alu_op
);

  localparam int HI_W = ADDR_W - DATA_W;

  seq_state_t        st_q, st_d;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] opc_q;
  logic [DATA_W-1:0] pend_op_q;
  logic              pend_q;
  logic              cross_q;

  logic pc_inc, opc_ld, base_ld, hi_ld, sum_ld, pend_set, fetch_clr;

  // during a fetch the opcode is still on the bus; later it is held
  assign op_hdr = (st_q == ST_FETCH) ? data_in[HDR_LSB +: HDR_W]
                                     : opc_q[HDR_LSB +: HDR_W];

  always_comb begin
    st_d      = st_q;
    pc_inc    = 1'b0;
    opc_ld    = 1'b0;
    base_ld   = 1'b0;
    hi_ld     = 1'b0;
    sum_ld    = 1'b0;
    pend_set  = 1'b0;
    fetch_clr = 1'b0;
    addr      = pc_q;
    wr        = 1'b0;
    alu_en    = 1'b0;
    alu_op    = '0;
    unique case (st_q)
      ST_FETCH: begin
        opc_ld    = 1'b1;
        pc_inc    = 1'b1;
        fetch_clr = 1'b1;
        alu_en    = pend_q;
        alu_op    = pend_op_q;
        st_d      = (is_zp || is_abs) ? ST_OPA : ST_FETCH;
      end
      ST_OPA: begin
        base_ld = 1'b1;
        pc_inc  = 1'b1;
        st_d    = ST_OPB;
      end
      ST_OPB: begin
        sum_ld = 1'b1;
        if (is_zp) begin
          addr = ea_zp_base;
        end else begin
          hi_ld  = 1'b1;
          pc_inc = 1'b1;
        end
        st_d = ST_EA;
      end
      ST_EA: begin
        if (is_zp) begin
          addr = ea_zp;
          if (is_store) begin
            wr   = 1'b1;
            st_d = ST_FETCH;
          end else if (is_rmw) begin
            st_d = ST_MOD;
          end else begin
            pend_set = 1'b1;
            st_d     = ST_FETCH;
          end
        end else begin
          addr = ea_abs;
          if (cross_q) begin
            st_d = ST_FIX;
          end else begin
            pend_set = 1'b1;
            st_d     = ST_FETCH;
          end
        end
      end
      ST_FIX: begin
        addr     = ea_fix;
        pend_set = 1'b1;
        st_d     = ST_FETCH;
      end
      ST_MOD: begin
        addr   = ea_zp;
        wr     = 1'b1;
        alu_en = 1'b1;
        alu_op = opc_q;
        st_d   = ST_WB;
      end
      ST_WB: begin
        addr = ea_zp;
        wr   = 1'b1;
        st_d = ST_FETCH;
      end
      default: st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_FETCH;
      pc_q      <= rst_pc;
      opc_q     <= '0;
      base_q    <= '0;
      hi_q      <= '0;
      eff_lo_q  <= '0;
      cross_q   <= 1'b0;
      pend_q    <= 1'b0;
      pend_op_q <= '0;
    end else begin
      st_q <= st_d;
      if (pc_inc) pc_q <= pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      if (opc_ld) opc_q <= data_in;
      if (base_ld) base_q <= data_in;
      if (hi_ld) hi_q <= data_in[HI_W-1:0];
      if (sum_ld) begin
        eff_lo_q <= sum_lo;
        cross_q  <= carry & is_abs;
      end else if (fetch_clr) begin
        cross_q <= 1'b0;
      end
      if (pend_set) begin
        pend_q    <= 1'b1;
        pend_op_q <= opc_q;
      end else if (fetch_clr) begin
        pend_q    <= 1'b0;
        pend_op_q <= '0;
      end
    end
  end

endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rst_pc,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  output logic [ADDR_W-1:0] addr,
  output logic              wr,
  output logic              alu_en,
  output logic [DATA_W-1:0] alu_op
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;

  // asynchronous assertion, release after SYNC_N edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  logic [HDR_W-1:0]  op_hdr;
  op_class_t         cls;
  logic [DATA_W-1:0] index;
  logic [DATA_W-1:0] base_q, eff_lo_q, sum_lo;
  logic [HI_W-1:0]   hi_q;
  logic              carry;
  logic [ADDR_W-1:0] ea_zp_base, ea_zp, ea_abs, ea_fix;

  idx_seq_decode u_dec (
    .hdr (op_hdr),
    .cls (cls)
  );

  assign index = cls.use_y ? idx_y : idx_x;

  idx_seq_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agen (
    .base       (base_q),
    .index      (index),
    .hi_part    (hi_q),
    .eff_lo     (eff_lo_q),
    .sum_lo     (sum_lo),
    .carry      (carry),
    .ea_zp_base (ea_zp_base),
    .ea_zp      (ea_zp),
    .ea_abs     (ea_abs),
    .ea_fix     (ea_fix)
  );

  idx_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rst_pc     (rst_pc),
    .data_in    (data_in),
    .is_zp      (cls.is_zp),
    .is_abs     (cls.is_abs),
    .is_store   (cls.is_store),
    .is_rmw     (cls.is_rmw),
    .sum_lo     (sum_lo),
    .carry      (carry),
    .ea_zp_base (ea_zp_base),
    .ea_zp      (ea_zp),
    .ea_abs     (ea_abs),
    .ea_fix     (ea_fix),
    .op_hdr     (op_hdr),
    .base_q     (base_q),
    .hi_q       (hi_q),
    .eff_lo_q   (eff_lo_q),
    .addr       (addr),
    .wr         (wr),
    .alu_en     (alu_en),
    .alu_op     (alu_op)
  );

endmodule

// File: rtl/idx_seq_chk.sv
module idx_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_n_s,
  input logic [ADDR_W-1:0] rst_pc,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic              alu_en,
  input logic [DATA_W-1:0] alu_op
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (!rst_n && $stable(rst_pc)) |-> (addr == rst_pc && !wr && !alu_en && alu_op == '0));

  // R11
  alu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !alu_en |-> (alu_op == '0));

  // R9
  rmw_mod_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alu_en && wr) |-> (!$past(wr) && $stable(addr)));

  // R9
  rmw_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alu_en && wr) |=> (wr && !alu_en && $stable(addr)));

  // R10
  pend_once_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alu_en && !wr) |=> !alu_en);

  // R8
  write_page0_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr |-> (addr[ADDR_W-1:DATA_W] == '0));

  // R11
  write_run_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && $past(wr)) |=> !wr);

endmodule

bind idx_seq idx_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_n_s (rst_n_s),
  .rst_pc  (rst_pc),
  .addr    (addr),
  .wr      (wr),
  .alu_en  (alu_en),
  .alu_op  (alu_op)
);

// File: tb/sim_idx_seq.sv
module sim_idx_seq;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 90;
  localparam int PROG_LEN   = 30;

  localparam logic [7:0] PROG [PROG_LEN] = '{
    8'h00,                 // plain
    8'h41, 8'h30,          // zp read, X
    8'h4A, 8'hF0,          // zp read, Y
    8'h52, 8'hF8,          // zp store, X
    8'h63, 8'h05,          // zp rmw, X
    8'h81, 8'h20, 8'h13,   // abs read, X
    8'h89, 8'hF0, 8'hE4,   // abs read, Y
    8'h95, 8'hFF, 8'h1F,   // abs with store class bits, X
    8'hC0,                 // plain, mode 11
    8'h44, 8'h10,          // zp read, X
    8'h59, 8'h7F,          // zp store, Y
    8'h6C, 8'h80,          // zp rmw, Y
    8'hA7, 8'h01, 8'h00,   // abs with rmw class bits, X
    8'h48, 8'h00           // zp read, Y
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] rst_pc;
  logic [7:0]  idx_x, idx_y;
  logic [7:0]  data_in;
  logic [12:0] addr;
  logic        wr, alu_en;
  logic [7:0]  alu_op;
  logic [7:0]  mem [256];

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    int    a;
    bit    w;
    bit    e;
    int    o;
    string t;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign data_in = mem[addr[7:0]];

  idx_seq u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_pc  (rst_pc),
    .data_in (data_in),
    .idx_x   (idx_x),
    .idx_y   (idx_y),
    .addr    (addr),
    .wr      (wr),
    .alu_en  (alu_en),
    .alu_op  (alu_op)
  );

  function automatic int rd(int a);
    return int'(mem[a & 255]);
  endfunction

  function automatic void push(int a, bit w, bit e, int o, string t);
    exp_t x;
    x.a = a; x.w = w; x.e = e; x.o = o; x.t = t;
    q.push_back(x);
  endfunction

  // behavioural trace of the expected bus cycles
  task automatic build(int start, int xv, int yv, int n);
    int pc  = start;
    bit pen = 1'b0;
    int pop = 0;
    bit first = 1'b1;
    q.delete();
    while (q.size() < n) begin
      int op, mode, cls, ix, base, lo, hi, sum, ea;
      bit uy;
      op = rd(pc);
      push(pc, 1'b0, pen, pen ? pop : 0, pen ? "R10" : (first ? "R13" : "R2 R11"));
      first = 1'b0;
      pen   = 1'b0;
      pc    = (pc + 1) & 8191;
      mode  = (op >> 6) & 3;
      cls   = (op >> 4) & 3;
      uy    = ((op >> 3) & 1) == 1;
      ix    = uy ? yv : xv;
      if (mode == 1) begin
        base = rd(pc);
        push(pc, 1'b0, 1'b0, 0, "R6 R11");
        pc = (pc + 1) & 8191;
        push(base, 1'b0, 1'b0, 0, "R6 R11");
        ea = (base + ix) & 255;
        if (cls == 1) begin
          push(ea, 1'b1, 1'b0, 0, uy ? "R7 R8" : "R8");
        end else if (cls == 2) begin
          push(ea, 1'b0, 1'b0, 0, uy ? "R7 R9" : "R6 R9");
          push(ea, 1'b1, 1'b1, op, "R9");
          push(ea, 1'b1, 1'b0, 0, "R9");
        end else begin
          push(ea, 1'b0, 1'b0, 0, uy ? "R7" : "R6");
          pen = 1'b1;
          pop = op;
        end
      end else if (mode == 2) begin
        lo = rd(pc);
        push(pc, 1'b0, 1'b0, 0, "R3");
        pc = (pc + 1) & 8191;
        hi = rd(pc) & 31;
        push(pc, 1'b0, 1'b0, 0, "R3");
        pc  = (pc + 1) & 8191;
        sum = lo + ix;
        push(hi * 256 + (sum & 255), 1'b0, 1'b0, 0,
             (cls != 0) ? "R12" : (uy ? "R7 R4" : "R4"));
        if (sum > 255)
          push(((hi + 1) & 31) * 256 + (sum & 255), 1'b0, 1'b0, 0, "R5");
        pen = 1'b1;
        pop = op;
      end
    end
  endtask

  task automatic cmp(exp_t x);
    checks++;
    if (addr !== x.a[12:0] || wr !== x.w || alu_en !== x.e || alu_op !== x.o[7:0]) begin
      failures++;
      $display("FAIL %s: got addr=%h wr=%b alu_en=%b alu_op=%h, expected addr=%h wr=%b alu_en=%b alu_op=%h",
               x.t, addr, wr, alu_en, alu_op, x.a[12:0], x.w, x.e, x.o[7:0]);
    end
  endtask

  task automatic run(int start, int xv, int yv, int at);
    exp_t idle;
    rst_n = 1'b0;
    idx_x = xv[7:0];
    idx_y = yv[7:0];
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < PROG_LEN; i++) mem[(at + i) & 255] = PROG[i];
    rst_pc = start[12:0];
    repeat (3) @(negedge clk);
    idle.a = start; idle.w = 1'b0; idle.e = 1'b0; idle.o = 0; idle.t = "R1";
    cmp(idle);
    build(start, xv, yv, RUN_CYCLES);
    rst_n = 1'b1;
    // first edge after release: still held (R13)
    @(negedge clk);
    idle.t = "R13";
    cmp(idle);
    for (int k = 0; k < RUN_CYCLES; k++) begin
      @(negedge clk);
      cmp(q.pop_front());
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    rst_pc = 13'h0100;
    idx_x  = 8'h00;
    idx_y  = 8'h00;
    run(13'h0100, 8'h10, 8'h20, 8'h00);
    run(13'h1FF8, 8'hF0, 8'h01, 8'hF8);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog: run did not complete, got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule